// File: doc/BRIEF.md
# Quadrature Rate Divider

This block slows down an incremental rotary encoder. It takes the two phase lines of the encoder and produces a new pair of quadrature signals at one half or one quarter of the input rate. The sense of rotation is kept, and the two output lines stay a quarter period apart.

The two input lines are handled jointly. Every change of the first line is steered by the level of the second line into one of two toggle stages. The two stage outputs form the divided pair. A one-time alignment latch arms at reset. It clears both toggle stages on the first cycle in which both inputs are high, so that direction and phase come out right no matter where the knob was when power came up.

Divide-by-4 is built by feeding the divide-by-2 pair through a second identical steering stage. A ratio select picks which pair drives the outputs. A new ratio takes effect only at a point where both stages rest at zero.

Top module: `quad_rate_divider`

## Requirements
- R1: While rst_n is low, and in the first cycles after it is released, out_a and out_b are 0.
- R2: Until the first cycle in which both synchronised inputs are high, out_a and out_b stay 0 whatever the inputs do.
- R3: When both synchronised inputs are first seen high together, the alignment latch sets and all toggle stages are cleared, so the outputs read 00 afterwards.
- R4: Once the alignment latch is set, later both-high input states never clear the stages again. Only a new reset re-arms the latch.
- R5: In divide-by-2 mode, a change of enc_a (either direction) while enc_b is 1 toggles out_b. A change of enc_a while enc_b is 0 toggles out_a. enc_b changes alone move nothing.
- R6: Successive output values differ in at most one bit, and one output period spans two input quadrature periods in divide-by-2 mode.
- R7: Reversing the input rotation reverses which output line leads.
- R8: With div4_sel = 1, the outputs come from a second steering stage. That stage is driven by the divide-by-2 pair, with its a input being the divide-by-2 out_a and its b input being the divide-by-2 out_b. One output period then spans four input periods.
- R9: A new value of div4_sel is adopted only when every toggle of both stages is 0 and no edge is pending in the second stage, or while the latch is not yet set. Until then, the previous ratio drives the outputs.
- R10: If an enc_a edge arrives in the same cycle as the alignment clear, the clear wins and the edge does not toggle any stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase line A, asynchronous |
| enc_b | input | 1 | Encoder phase line B, asynchronous |
| div4_sel | input | 1 | Ratio select: 0 divides by 2, 1 divides by 4 |
| out_a | output | 1 | Divided phase line A, registered |
| out_b | output | 1 | Divided phase line B, registered |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This lengthens the input-to-output latency and shows that the alignment and steering logic do not depend on the synchroniser depth. The bench waits a settle window after each input step that covers the deeper chain. With that setting, the bench can drive full forward and reverse rotations in both ratios, a ratio change in the middle of a cycle, and an edge that coincides with the alignment clear.

// File: rtl/quad_div_pkg.sv
package quad_div_pkg;
  typedef enum logic {
    RATIO_DIV2 = 1'b0,
    RATIO_DIV4 = 1'b1
  } ratio_e;

  typedef struct packed {
    logic a;
    logic b;
  } quad_pair_t;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_flop
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qd_stage.sv
module qd_stage
  import quad_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  quad_pair_t in_pair,
  input  logic       clr,
  input  logic       prev_on_clr,
  output quad_pair_t out_pair,
  output logic       evt
);
  logic a_q, a_nx;
  logic hi_q, hi_nx;
  logic lo_q, lo_nx;

  // an edge of the A line, either direction
  assign evt = in_pair.a ^ a_q;

  always_comb begin
    a_nx  = in_pair.a;
    hi_nx = hi_q;
    lo_nx = lo_q;
    if (clr) begin
      a_nx  = prev_on_clr;
      hi_nx = 1'b0;
      lo_nx = 1'b0;
    end else if (evt) begin
      if (in_pair.b) hi_nx = ~hi_q;
      else           lo_nx = ~lo_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= 1'b0;
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      a_q  <= a_nx;
      hi_q <= hi_nx;
      lo_q <= lo_nx;
    end
  end

  assign out_pair.a = lo_q;
  assign out_pair.b = hi_q;
endmodule

// File: rtl/quad_rate_divider.sv
module quad_rate_divider
  import quad_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a,
  input  logic enc_b,
  input  logic div4_sel,
  output logic out_a,
  output logic out_b
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_s;
  logic             in_a_s, in_b_s;
  quad_pair_t       in_pair, half_pair, quarter_pair, pick_pair;
  logic             half_evt, quarter_evt;
  logic             synced_q, synced_nx, sync_now;
  ratio_e           ratio_q, ratio_nx;
  logic             ratio_en, stages_idle;
  logic             out_a_nx, out_b_nx;

  qd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({enc_a, enc_b}),
    .q (raw_s)
  );

  assign in_a_s    = raw_s[1];
  assign in_b_s    = raw_s[0];
  assign in_pair.a = in_a_s;
  assign in_pair.b = in_b_s;

  // one-time alignment: first both-high state after reset
  assign sync_now  = ~synced_q & in_a_s & in_b_s;
  assign synced_nx = synced_q | sync_now;

  qd_stage u_half (
    .clk (clk),
    .rst_n (rst_n),
    .in_pair (in_pair),
    .clr (sync_now),
    .prev_on_clr (in_a_s),
    .out_pair (half_pair),
    .evt (half_evt)
  );

  qd_stage u_quarter (
    .clk (clk),
    .rst_n (rst_n),
    .in_pair (half_pair),
    .clr (sync_now),
    .prev_on_clr (1'b0),
    .out_pair (quarter_pair),
    .evt (quarter_evt)
  );

  // ratio switch only at a common rest point of both stages
  assign stages_idle = (half_pair == '0) && (quarter_pair == '0) && !quarter_evt;
  assign ratio_en    = !synced_q || stages_idle;
  assign ratio_nx    = ratio_en ? ratio_e'(div4_sel) : ratio_q;

  always_comb begin
    pick_pair = (ratio_q == RATIO_DIV4) ? quarter_pair : half_pair;
    out_a_nx  = synced_q & pick_pair.a;
    out_b_nx  = synced_q & pick_pair.b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      ratio_q  <= RATIO_DIV2;
      out_a    <= 1'b0;
      out_b    <= 1'b0;
    end else begin
      synced_q <= synced_nx;
      ratio_q  <= ratio_nx;
      out_a    <= out_a_nx;
      out_b    <= out_b_nx;
    end
  end
endmodule

// File: rtl/quad_rate_divider_checker.sv
module quad_rate_divider_checker (
  input logic clk,
  input logic rst_n,
  input logic out_a,
  input logic out_b,
  input logic a_s,
  input logic b_s,
  input logic synced,
  input logic ratio
);
  AST_LOW_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |=> (!out_a && !out_b)); // R2

  AST_SYNC_ON_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && a_s && b_s) |=> synced); // R3

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced); // R4

  AST_SINGLE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_a, out_b} ^ $past({out_a, out_b})) <= 1); // R6

  AST_RATIO_SWAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != $past(ratio)) |-> (!out_a && !out_b)); // R9
endmodule

bind quad_rate_divider quad_rate_divider_checker u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .out_a (out_a),
  .out_b (out_b),
  .a_s (in_a_s),
  .b_s (in_b_s),
  .synced (synced_q),
  .ratio (ratio_q)
);

// File: tb/quad_rate_divider_bench.sv
`timescale 1ns/1ps
module quad_rate_divider_bench;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, div4_sel = 1'b0;
  logic out_a, out_b;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_lo, m_hi, m_qlo, m_qhi, m_sync, m_r4, m_pa;

  logic [1:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;

  always #10 clk = ~clk;

  quad_rate_divider #(.SYNC_STAGES(3)) u_quad_rate_divider (
    .clk (clk), .rst_n (rst_n), .enc_a (enc_a), .enc_b (enc_b),
    .div4_sel (div4_sel), .out_a (out_a), .out_b (out_b)
  );

  function automatic logic [1:0] model_out();
    if (!m_sync) return 2'b00;
    return m_r4 ? {m_qlo, m_qhi} : {m_lo, m_hi};
  endfunction

  function automatic void model_ratio();
    if (!m_sync || !(m_lo | m_hi | m_qlo | m_qhi)) m_r4 = div4_sel;
  endfunction

  task automatic push_check(string tag);
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
    repeat (SETTLE) @(negedge clk);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic step(bit a, bit b, string tag);
    @(negedge clk);
    enc_a = a; enc_b = b;
    if (!m_sync && a && b) begin
      m_sync = 1; m_lo = 0; m_hi = 0; m_qlo = 0; m_qhi = 0;
    end else if (a != m_pa) begin
      if (b) m_hi = ~m_hi;
      else begin
        m_lo = ~m_lo;
        if (m_hi) m_qhi = ~m_qhi;
        else      m_qlo = ~m_qlo;
      end
    end
    m_pa = a;
    model_ratio();
    push_check(tag);
  endtask

  task automatic set_sel(bit s, string tag);
    @(negedge clk);
    div4_sel = s;
    model_ratio();
    push_check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; enc_a = 0; enc_b = 0;
    m_lo = 0; m_hi = 0; m_qlo = 0; m_qhi = 0; m_sync = 0; m_pa = 0;
    m_r4 = div4_sel;
    repeat (3) @(negedge clk);
    n_tests++;
    if ({out_a, out_b} !== 2'b00) begin
      n_fail++;
      $display("FAIL R1 in reset: got %b expected 00", {out_a, out_b});
    end
    rst_n = 1;
    @(negedge clk);
    n_tests++;
    if ({out_a, out_b} !== 2'b00) begin
      n_fail++;
      $display("FAIL R1 after release: got %b expected 00", {out_a, out_b});
    end
  endtask

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({out_a, out_b} !== e) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", t, {out_a, out_b}, e);
        end
      end
    end
  end

  task automatic cw(int n, string tag);
    for (int i = 0; i < n; i++) begin
      step(1, 0, tag); step(1, 1, tag); step(0, 1, tag); step(0, 0, tag);
    end
  endtask

  task automatic ccw(int n, string tag);
    for (int i = 0; i < n; i++) begin
      step(0, 1, tag); step(1, 1, tag); step(1, 0, tag); step(0, 0, tag);
    end
  endtask

  initial begin
    do_reset();
    set_sel(0, "R9 ratio before sync");
    // R2: movement that never shows both-high
    step(1, 0, "R2"); step(0, 0, "R2"); step(1, 0, "R2"); step(0, 0, "R2");
    step(0, 1, "R2"); step(0, 0, "R2");
    // R3: first both-high aligns
    step(1, 0, "R3"); step(1, 1, "R3 aligned");
    // R5/R6: forward rotation at divide-by-2
    step(0, 1, "R5"); step(0, 0, "R5");
    cw(3, "R6 forward div2");
    // R4: both-high states revisited without a re-clear
    step(1, 0, "R4"); step(1, 1, "R4 no resync");
    step(1, 0, "R7"); step(0, 0, "R7");
    // R7: reverse rotation
    ccw(3, "R7 reverse div2");
    // R9: ratio change in mid cycle is deferred
    step(0, 1, "R9"); step(1, 1, "R9");
    set_sel(1, "R9 deferred");
    step(1, 0, "R9"); step(0, 0, "R9");
    cw(2, "R9 switch point");
    // R8: divide-by-4 both directions
    cw(4, "R8 forward div4");
    ccw(4, "R8 reverse div4");
    set_sel(0, "R9 back to div2");
    cw(2, "R9 div2 again");
    // R10: edge in the alignment cycle is dropped; R4 reset re-arms
    do_reset();
    step(0, 1, "R10"); step(1, 1, "R10 clear wins");
    step(0, 1, "R10 first move"); step(0, 0, "R10");
    cw(2, "R4 re-armed");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule